// File: doc/BRIEF.md
# Pipeline Interlock Stall Controller

This block decides, every clock cycle, whether the instruction sitting in the Decode stage of a scalar, in-order, five-stage pipeline (Fetch, Decode, Execute, Memory, Writeback) may move on. The pipeline has no operand forwarding. A Decode instruction that reads a register still being produced by an older instruction in Execute or Memory is therefore held in place. The PC and the Decode register freeze, and an empty slot (a bubble) enters Execute in its place. Once the producer has left Memory, the held instruction proceeds.

The block carries a metadata-only copy of the pipeline so that stall sequences can be observed at its ports. The Decode register holds the full operand description. The Execute and Memory registers hold only what travels with an instruction: the valid bit, the destination, the register-write flag and the memory-write flag. The Writeback stage drives the register-file write port fields. A fetch interface supplies the description of the instruction at the current PC each cycle. Two free-running counters (cycles and retired instructions) let an environment check CPI against the expected stall count.

Top module: `interlock_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, PC is 0, the Decode, Execute, Memory and Writeback slots are empty (valid, register-write and memory-write all 0), and both counters are 0.
- R2: A stall is raised when a used, nonzero source register of the valid Decode instruction equals the destination of the instruction in Execute, and that instruction has its register-write flag set.
- R3: A stall is raised under the same condition against the instruction in Memory.
- R4: A destination match against an older instruction whose register-write flag is 0 never causes a stall, even if its memory-write flag is 1.
- R5: Register number 0 never causes a stall, whether it appears as source or as destination.
- R6: A source field whose use bit is 0 never causes a stall.
- R7: In a stall cycle, the PC write enable and the Decode write enable are both 0, and the PC and the Decode slot keep their values at the next edge.
- R8: After a stall cycle, the Execute slot is a bubble: valid, register-write and memory-write are all 0.
- R9: A dependent instruction directly after its producer stalls exactly 2 cycles. With one independent instruction between them it stalls 1 cycle, and with two or more it does not stall. The stall condition is re-evaluated every cycle, and no stall run is longer than 2 cycles.
- R10: In a cycle without a stall, the PC advances by exactly 1 at the next edge, and each instruction moves one stage per cycle: Decode to Execute, then Memory, then Writeback.
- R11: The cycle counter increments by 1 every cycle out of reset. The retire counter increments by 1 at each edge where Writeback holds a valid instruction, and never at any other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Instruction at PC is real (0 fetches an empty slot) |
| fetch_dst | input | 5 | Destination register number |
| fetch_src_a | input | 5 | First source register number |
| fetch_src_b | input | 5 | Second source register number |
| fetch_use_a | input | 1 | First source is actually read |
| fetch_use_b | input | 1 | Second source is actually read |
| fetch_reg_wr | input | 1 | Instruction writes its destination register |
| fetch_mem_wr | input | 1 | Instruction writes memory |
| pc | output | PC_W | Current fetch address |
| pc_we | output | 1 | PC write enable |
| d_we | output | 1 | Decode register write enable |
| x_bubble | output | 1 | Execute register loads a bubble at the next edge (stall) |
| x_valid | output | 1 | Execute slot holds an instruction |
| x_dst | output | 5 | Execute slot destination |
| x_reg_wr | output | 1 | Execute slot register-write flag |
| x_mem_wr | output | 1 | Execute slot memory-write flag |
| m_mem_wr | output | 1 | Memory-stage memory-write strobe |
| w_reg_wr | output | 1 | Writeback register-file write enable |
| w_dst | output | 5 | Writeback register-file write address |
| cycle_count | output | CNT_W | Cycles since reset |
| retire_count | output | CNT_W | Instructions retired since reset |

## Verification
The embedded properties watch, on every cycle, that a stall freezes the PC and the Decode slot, and that a stall always puts a bubble with cleared write flags into Execute. They also check that an unstalled cycle advances the PC by one, that no stall run exceeds two cycles, that register 0 and writes with no register-write flag never raise a stall, and that the counters step correctly. The exact stall length for a given producer distance, and whether the right instruction reaches Execute in the right cycle, can only be shown by the bench's scenarios. The bench schedules every instruction's Execute cycle from the dependence rules and compares the PC, the stall, the Execute slot and the retire count against that schedule in every cycle of both directed and random programs.

// File: rtl/interlock_pkg.sv
package interlock_pkg;

  parameter int REG_IDX_W = 5;

  typedef struct packed {
    logic                 valid;
    logic [REG_IDX_W-1:0] dst;
    logic [REG_IDX_W-1:0] src_a;
    logic [REG_IDX_W-1:0] src_b;
    logic                 use_a;
    logic                 use_b;
    logic                 reg_wr;
    logic                 mem_wr;
  } dec_uop_t;

  typedef struct packed {
    logic                 valid;
    logic [REG_IDX_W-1:0] dst;
    logic                 reg_wr;
    logic                 mem_wr;
  } ctl_t;

  localparam dec_uop_t DEC_EMPTY = '0;
  localparam ctl_t     CTL_EMPTY = '0;

endpackage

// File: rtl/interlock_hazard.sv
module interlock_hazard
  import interlock_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  dec_uop_t             d_uop,
  input  logic [REG_IDX_W-1:0] x_dst,
  input  logic                 x_reg_wr,
  input  logic [REG_IDX_W-1:0] m_dst,
  input  logic                 m_reg_wr,
  output logic                 hazard
);

  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0] src_hit;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic [REG_IDX_W-1:0] num;
    logic                 live;
    assign num  = (s == 0) ? d_uop.src_a : d_uop.src_b;
    assign live = d_uop.valid && ((s == 0) ? d_uop.use_a : d_uop.use_b) && (num != '0);
    assign src_hit[s] = live && ((x_reg_wr && (x_dst == num)) ||
                                 (m_reg_wr && (m_dst == num)));
  end

  assign hazard = |src_hit;

  // R4: older instructions without register write can never hold Decode
  assert_nowrite_nostall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!x_reg_wr && !m_reg_wr) |-> !hazard);

  // R5: an instruction that reads only register 0 is never held
  assert_zero_reg_nostall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((!d_uop.use_a || d_uop.src_a == '0) && (!d_uop.use_b || d_uop.src_b == '0)) |-> !hazard);

endmodule

// File: rtl/interlock_stages.sv
module interlock_stages
  import interlock_pkg::*;
#(
  parameter int PC_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  dec_uop_t             fetch_uop,
  input  logic                 stall,
  output logic [PC_W-1:0]      pc_q,
  output logic                 pc_we,
  output logic                 d_we,
  output dec_uop_t             d_q,
  output ctl_t                 x_q,
  output ctl_t                 m_q,
  output logic                 w_valid_q,
  output logic [REG_IDX_W-1:0] w_dst_q,
  output logic                 w_reg_wr_q
);

  logic [PC_W-1:0] pc_n;
  ctl_t            x_n;

  assign pc_we = !stall;
  assign d_we  = !stall;

  always_comb begin
    pc_n = pc_q + PC_W'(1);
    if (stall) begin
      x_n = CTL_EMPTY;
    end else begin
      x_n.valid  = d_q.valid;
      x_n.dst    = d_q.dst;
      x_n.reg_wr = d_q.reg_wr;
      x_n.mem_wr = d_q.mem_wr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q       <= '0;
      d_q        <= DEC_EMPTY;
      x_q        <= CTL_EMPTY;
      m_q        <= CTL_EMPTY;
      w_valid_q  <= 1'b0;
      w_dst_q    <= '0;
      w_reg_wr_q <= 1'b0;
    end else begin
      if (pc_we) pc_q <= pc_n;
      if (d_we)  d_q  <= fetch_uop;
      x_q        <= x_n;
      m_q        <= x_q;
      w_valid_q  <= m_q.valid;
      w_dst_q    <= m_q.dst;
      w_reg_wr_q <= m_q.reg_wr;
    end
  end

  // R7: a held cycle leaves PC and Decode untouched
  assert_stall_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(pc_q) && $stable(d_q)));

  // R8: a held cycle sends an empty, write-free slot into Execute
  assert_bubble_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (!x_q.valid && !x_q.reg_wr && !x_q.mem_wr));

  // R10: a free cycle steps the PC by one
  assert_pc_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> (pc_q == $past(pc_q) + PC_W'(1)));

endmodule

// File: rtl/interlock_counters.sv
module interlock_counters #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retire,
  output logic [CNT_W-1:0] cycle_q,
  output logic [CNT_W-1:0] retire_q
);

  logic [CNT_W-1:0] cycle_n;
  logic [CNT_W-1:0] retire_n;

  always_comb begin
    cycle_n  = cycle_q + CNT_W'(1);
    retire_n = retire_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cycle_q  <= '0;
      retire_q <= '0;
    end else begin
      cycle_q <= cycle_n;
      if (retire) retire_q <= retire_n;
    end
  end

  // R11: cycle count steps every cycle
  assert_cycle_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (cycle_q == $past(cycle_q) + CNT_W'(1)));

  // R11: retire count moves only with a valid Writeback slot
  assert_retire_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !retire |=> $stable(retire_q));

endmodule

// File: rtl/interlock_ctrl.sv
module interlock_ctrl
  import interlock_pkg::*;
#(
  parameter int PC_W  = 8,
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fetch_valid,
  input  logic [REG_IDX_W-1:0] fetch_dst,
  input  logic [REG_IDX_W-1:0] fetch_src_a,
  input  logic [REG_IDX_W-1:0] fetch_src_b,
  input  logic                 fetch_use_a,
  input  logic                 fetch_use_b,
  input  logic                 fetch_reg_wr,
  input  logic                 fetch_mem_wr,
  output logic [PC_W-1:0]      pc,
  output logic                 pc_we,
  output logic                 d_we,
  output logic                 x_bubble,
  output logic                 x_valid,
  output logic [REG_IDX_W-1:0] x_dst,
  output logic                 x_reg_wr,
  output logic                 x_mem_wr,
  output logic                 m_mem_wr,
  output logic                 w_reg_wr,
  output logic [REG_IDX_W-1:0] w_dst,
  output logic [CNT_W-1:0]     cycle_count,
  output logic [CNT_W-1:0]     retire_count
);

  dec_uop_t fetch_uop;
  dec_uop_t d_q;
  ctl_t     x_q;
  ctl_t     m_q;
  logic     hazard;
  logic     w_valid;

  always_comb begin
    fetch_uop.valid  = fetch_valid;
    fetch_uop.dst    = fetch_dst;
    fetch_uop.src_a  = fetch_src_a;
    fetch_uop.src_b  = fetch_src_b;
    fetch_uop.use_a  = fetch_use_a;
    fetch_uop.use_b  = fetch_use_b;
    fetch_uop.reg_wr = fetch_reg_wr;
    fetch_uop.mem_wr = fetch_mem_wr;
  end

  interlock_hazard u_hazard (
    .clk      (clk),
    .rst_n    (rst_n),
    .d_uop    (d_q),
    .x_dst    (x_q.dst),
    .x_reg_wr (x_q.reg_wr),
    .m_dst    (m_q.dst),
    .m_reg_wr (m_q.reg_wr),
    .hazard   (hazard)
  );

  interlock_stages #(.PC_W(PC_W)) u_stages (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_uop  (fetch_uop),
    .stall      (hazard),
    .pc_q       (pc),
    .pc_we      (pc_we),
    .d_we       (d_we),
    .d_q        (d_q),
    .x_q        (x_q),
    .m_q        (m_q),
    .w_valid_q  (w_valid),
    .w_dst_q    (w_dst),
    .w_reg_wr_q (w_reg_wr)
  );

  interlock_counters #(.CNT_W(CNT_W)) u_counters (
    .clk      (clk),
    .rst_n    (rst_n),
    .retire   (w_valid),
    .cycle_q  (cycle_count),
    .retire_q (retire_count)
  );

  assign x_bubble = hazard;
  assign x_valid  = x_q.valid;
  assign x_dst    = x_q.dst;
  assign x_reg_wr = x_q.reg_wr;
  assign x_mem_wr = x_q.mem_wr;
  assign m_mem_wr = m_q.mem_wr;

  // R9: a producer leaves Memory within two held cycles
  assert_stall_run_max2_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hazard && $past(hazard)) |=> !hazard);

endmodule

// File: tb/interlock_ctrl_bench.sv
`timescale 1ns/1ps
module interlock_ctrl_bench;

  localparam int PC_W  = 8;
  localparam int CNT_W = 16;
  localparam int MAXN  = 32;
  localparam int MAXC  = 128;

  logic clk = 1'b0;
  logic rst_n;
  logic fetch_valid, fetch_use_a, fetch_use_b, fetch_reg_wr, fetch_mem_wr;
  logic [4:0] fetch_dst, fetch_src_a, fetch_src_b;
  logic [PC_W-1:0] pc;
  logic pc_we, d_we, x_bubble, x_valid, x_reg_wr, x_mem_wr, m_mem_wr, w_reg_wr;
  logic [4:0] x_dst, w_dst;
  logic [CNT_W-1:0] cycle_count, retire_count;

  int checks = 0;
  int fails  = 0;

  int plen = 0;
  logic [4:0] p_dst [MAXN];
  logic [4:0] p_sa  [MAXN];
  logic [4:0] p_sb  [MAXN];
  bit p_ua [MAXN];
  bit p_ub [MAXN];
  bit p_rw [MAXN];
  bit p_mw [MAXN];
  int tx   [MAXN];
  bit stall_e [MAXC];

  always #10 clk = ~clk;

  interlock_ctrl #(.PC_W(PC_W), .CNT_W(CNT_W)) u_interlock_ctrl (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_dst(fetch_dst),
    .fetch_src_a(fetch_src_a), .fetch_src_b(fetch_src_b),
    .fetch_use_a(fetch_use_a), .fetch_use_b(fetch_use_b),
    .fetch_reg_wr(fetch_reg_wr), .fetch_mem_wr(fetch_mem_wr),
    .pc(pc), .pc_we(pc_we), .d_we(d_we), .x_bubble(x_bubble),
    .x_valid(x_valid), .x_dst(x_dst), .x_reg_wr(x_reg_wr), .x_mem_wr(x_mem_wr),
    .m_mem_wr(m_mem_wr), .w_reg_wr(w_reg_wr), .w_dst(w_dst),
    .cycle_count(cycle_count), .retire_count(retire_count)
  );

  // instruction memory model: answers the current PC
  always_comb begin
    int idx;
    idx = int'(pc);
    if (idx < plen) begin
      fetch_valid = 1'b1;   fetch_dst = p_dst[idx];
      fetch_src_a = p_sa[idx]; fetch_src_b = p_sb[idx];
      fetch_use_a = p_ua[idx]; fetch_use_b = p_ub[idx];
      fetch_reg_wr = p_rw[idx]; fetch_mem_wr = p_mw[idx];
    end else begin
      fetch_valid = 1'b0;   fetch_dst = '0;
      fetch_src_a = '0;     fetch_src_b = '0;
      fetch_use_a = 1'b0;   fetch_use_b = 1'b0;
      fetch_reg_wr = 1'b0;  fetch_mem_wr = 1'b0;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic add_ins(input int dst, input int sa, input bit ua, input int sb,
                         input bit ub, input bit rw, input bit mw);
    p_dst[plen] = 5'(dst); p_sa[plen] = 5'(sa); p_sb[plen] = 5'(sb);
    p_ua[plen] = ua; p_ub[plen] = ub; p_rw[plen] = rw; p_mw[plen] = mw;
    plen++;
  endtask

  // Execute-entry cycle of each instruction, from the dependence rules
  function automatic void schedule();
    for (int c = 0; c < MAXC; c++) stall_e[c] = 1'b0;
    tx[0] = 2;
    for (int i = 1; i < plen; i++) begin
      int t;
      t = tx[i-1] + 1;
      for (int j = 0; j < i; j++) begin
        if (p_rw[j] && p_dst[j] != 0 &&
            ((p_ua[i] && p_sa[i] == p_dst[j]) || (p_ub[i] && p_sb[i] == p_dst[j])))
          if (tx[j] + 3 > t) t = tx[j] + 3;
      end
      tx[i] = t;
      for (int c = tx[i-1]; c <= tx[i] - 2; c++) stall_e[c] = 1'b1;
    end
  endfunction

  function automatic int retired_by(input int c);
    int n = 0;
    for (int i = 0; i < plen; i++) if (tx[i] + 3 <= c) n++;
    return n;
  endfunction

  task automatic run_prog(input string tag, input int exp_stalls);
    int pc_e = 0;
    int nst = 0;
    int last;
    schedule();
    last = tx[plen-1] + 4;
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1", "pc in reset", int'(pc), 0);
    chk("R1", "x_valid in reset", int'(x_valid), 0);
    chk("R1", "retire in reset", int'(retire_count), 0);
    rst_n = 1'b1;
    #1;
    chk("R1", "cycle count after release", int'(cycle_count), 0);
    for (int c = 0; c <= last; c++) begin
      int xi = -1;
      for (int i = 0; i < plen; i++) if (tx[i] == c) xi = i;
      chk(tag, $sformatf("stall cycle %0d", c), int'(x_bubble), int'(stall_e[c]));
      chk("R7", $sformatf("pc_we cycle %0d", c), int'(pc_we), int'(!stall_e[c]));
      chk("R7", $sformatf("d_we cycle %0d", c), int'(d_we), int'(!stall_e[c]));
      chk("R10", $sformatf("pc cycle %0d", c), int'(pc), pc_e);
      if (xi >= 0) begin
        chk("R10", $sformatf("x_valid cycle %0d", c), int'(x_valid), 1);
        chk("R10", $sformatf("x_dst cycle %0d", c), int'(x_dst), int'(p_dst[xi]));
        chk("R10", $sformatf("x_reg_wr cycle %0d", c), int'(x_reg_wr), int'(p_rw[xi]));
      end else begin
        chk("R8", $sformatf("bubble slot cycle %0d", c),
            int'({x_valid, x_reg_wr, x_mem_wr}), 0);
      end
      chk("R11", $sformatf("retire cycle %0d", c), int'(retire_count), retired_by(c));
      chk("R11", $sformatf("cycles cycle %0d", c), int'(cycle_count), c);
      if (stall_e[c]) nst++;
      else pc_e++;
      @(posedge clk);
      @(negedge clk);
    end
    if (exp_stalls >= 0) chk(tag, "total stall cycles", nst, exp_stalls);
    chk("R11", "final retire = program length", int'(retire_count), plen);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    repeat (2) @(posedge clk);

    // R2 R9: adjacent dependence, two held cycles
    plen = 0;
    add_ins(1, 2, 1, 3, 1, 1, 0);
    add_ins(4, 1, 1, 0, 0, 1, 0);
    run_prog("R2", 2);

    // R3 R9: one independent between, one held cycle; then a distance of three, none
    plen = 0;
    add_ins(2, 0, 0, 0, 0, 1, 0);
    add_ins(3, 4, 1, 5, 1, 1, 0);
    add_ins(6, 7, 1, 2, 1, 1, 0);
    add_ins(8, 0, 0, 0, 0, 1, 0);
    add_ins(9, 0, 0, 0, 0, 0, 0);
    add_ins(10, 11, 1, 0, 0, 0, 0);
    add_ins(12, 8, 1, 0, 0, 1, 0);
    run_prog("R3", 1);

    // R9: dependence on the second source, two instructions between, no hold
    plen = 0;
    add_ins(5, 0, 0, 0, 0, 1, 0);
    add_ins(6, 0, 0, 0, 0, 1, 0);
    add_ins(7, 0, 0, 0, 0, 1, 0);
    add_ins(8, 1, 1, 5, 1, 1, 0);
    run_prog("R9", 0);

    // R4: store-like producer without register write
    plen = 0;
    add_ins(1, 2, 1, 3, 1, 0, 1);
    add_ins(4, 1, 1, 1, 1, 1, 0);
    run_prog("R4", 0);

    // R5: register 0 as destination and source
    plen = 0;
    add_ins(0, 2, 1, 0, 0, 1, 0);
    add_ins(3, 0, 1, 0, 1, 1, 0);
    run_prog("R5", 0);

    // R6: matching sources marked unused
    plen = 0;
    add_ins(1, 0, 0, 0, 0, 1, 0);
    add_ins(2, 1, 0, 1, 0, 1, 0);
    run_prog("R6", 0);

    // R9: dependent chain, every link held two cycles
    plen = 0;
    add_ins(1, 0, 0, 0, 0, 1, 0);
    add_ins(2, 1, 1, 0, 0, 1, 0);
    add_ins(3, 0, 0, 2, 1, 1, 1);
    add_ins(4, 3, 1, 3, 1, 1, 0);
    run_prog("R9", 6);

    // R9: random programs over a small register set
    for (int r = 0; r < 6; r++) begin
      plen = 0;
      for (int k = 0; k < 20; k++)
        add_ins(int'($urandom % 4), int'($urandom % 4), bit'($urandom % 2),
                int'($urandom % 4), bit'($urandom % 2), bit'($urandom % 2),
                bit'($urandom % 2));
      run_prog("R9", -1);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule